// File: doc/BRIEF.md
# Thermostatic Fan Mode Sequencer

This block is the control core of a thermostatic fan controller. It watches two digitized control levels (a primary temperature level and a secondary fan-demand level) together with a programmable sleep level, and it decides which of four modes the fan drive is in: off because the primary level has been pulled very low, kicking the fan with a forced-on output, running under proportional PWM control, or asleep because everything is cool. A separate PWM generator supplies a one-cycle pulse at the start of each PWM period; this block counts those pulses to time the kick, and tells the generator whether to run, whether to force its output high, and whether the output pin should float.

The primary level has two shutdown thresholds, giving hysteresis. When that level drops below the lower threshold, the drive enable and the force request fall in the same cycle, through a combinational path. The internal mode follows after the input passes through a synchronizer. A restart happens only once the level climbs above the higher threshold. Every restart from an off state (power-up, release from shutdown, wake from sleep) runs the same kick of 64 PWM periods before proportional control takes over. An active-low hot flag tracks the primary level against the overtemperature threshold while the fan is active.

All ports are plain level or pulse control signals. No data stream crosses this block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `fan_mode_seq`

## Requirements
- R1: While `rst_n` is low, `pwm_en`, `force_high` and `out_float` are 0 and `hot_n` is 1. After release with `ctl1_lvl` above the start threshold (default code 20), `force_high` is 1 within three cycles.
- R2: In the same cycle that `ctl1_lvl` is below the stop threshold (default code 12), `pwm_en`, `force_high` and `out_float` are 0 and `hot_n` is 1, whatever `ctl2_lvl` holds.
- R3: Once stopped, the block stays stopped while `ctl1_lvl` lies between the stop and start thresholds. When `ctl1_lvl` rises above the start threshold, the kick begins.
- R4: The kick holds `force_high` at 1 and `pwm_en` at 0 through 63 period-start pulses. In the cycle after the 64th pulse, `force_high` is 0 and `pwm_en` is 1.
- R5: In the running mode, sleep is entered when both `ctl1_lvl` and `ctl2_lvl` are below `slp_lvl`. Sleep then shows as `out_float`=1 and `pwm_en`=0. Only one level below `slp_lvl` does not cause sleep.
- R6: Sleep ends only when either level exceeds `slp_lvl` + HYST (default HYST 28). Waking starts a fresh 64-period kick.
- R7: With `slp_lvl` = 0, the block never enters sleep, even with both levels very low (but above the stop threshold).
- R8: In the kick and running modes, `hot_n` is 0 exactly when `ctl1_lvl` is above the overtemperature code (default 196), and `pwm_en` or `force_high` is unaffected by it.
- R9: During sleep, `hot_n` is 1 even when `ctl1_lvl` is above the overtemperature code.
- R10: At most one of `pwm_en`, `force_high` and `out_float` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic time base |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ctl1_lvl | input | 8 | Primary control level, full-scale code |
| ctl2_lvl | input | 8 | Secondary control level, full-scale code |
| slp_lvl | input | 8 | Sleep level; 0 disables sleep |
| period_start | input | 1 | One-cycle pulse at each PWM period start |
| pwm_en | output | 1 | Run proportional PWM |
| force_high | output | 1 | Force drive output high (kick) |
| hot_n | output | 1 | Overtemperature flag, active low |
| out_float | output | 1 | Drive output should float (sleep) |

## Verification
The assertions assume that all level inputs are synchronous to `clk`, and that `period_start` is high for one cycle at a time. They also assume that `slp_lvl` plus the hysteresis leaves room below full scale for a wake to be possible. The bench changes every input just after a falling edge and pulses `period_start` for a single cycle. Its random levels stay above the stop threshold, except for the directed shutdown cases, so that mode changes come only from the intended corners.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_KICK  = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_SLEEP = 2'd3
  } fan_mode_e;
endpackage

// File: rtl/fan_lvl_cmp.sv
module fan_lvl_cmp #(
  parameter int LVL_W   = 8,
  parameter int STOP_LO = 12,
  parameter int START_HI = 20,
  parameter int HOT_LVL = 196,
  parameter int HYST    = 28
) (
  input  logic [LVL_W-1:0] ctl1_lvl,
  input  logic [LVL_W-1:0] ctl2_lvl,
  input  logic [LVL_W-1:0] slp_lvl,
  output logic             stop_now,
  output logic             start_ok,
  output logic             hot,
  output logic             sleep_req,
  output logic             wake_req
);
  localparam logic [LVL_W-1:0] STOP_C  = LVL_W'(STOP_LO);
  localparam logic [LVL_W-1:0] START_C = LVL_W'(START_HI);
  localparam logic [LVL_W-1:0] HOT_C   = LVL_W'(HOT_LVL);
  localparam logic [LVL_W:0]   HYST_C  = (LVL_W+1)'(HYST);

  logic [LVL_W:0] wake_lvl;

  always_comb begin
    wake_lvl  = {1'b0, slp_lvl} + HYST_C;
    stop_now  = ctl1_lvl < STOP_C;
    start_ok  = ctl1_lvl > START_C;
    hot       = ctl1_lvl > HOT_C;
    sleep_req = (slp_lvl != '0) && (ctl1_lvl < slp_lvl) && (ctl2_lvl < slp_lvl);
    wake_req  = ({1'b0, ctl1_lvl} > wake_lvl) || ({1'b0, ctl2_lvl} > wake_lvl);
  end
endmodule

// File: rtl/fan_stop_sync.sv
module fan_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fan_kick_cnt.sv
module fan_kick_cnt #(
  parameter int KICK_PERIODS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);
  localparam int CW = (KICK_PERIODS > 1) ? $clog2(KICK_PERIODS) : 1;
  localparam logic [CW-1:0] LAST = CW'(KICK_PERIODS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;

  assign done = tick && !clr && (cnt == LAST);
endmodule

// File: rtl/fan_mode_seq.sv
module fan_mode_seq #(
  parameter int LVL_W        = 8,
  parameter int STOP_LO      = 12,
  parameter int START_HI     = 20,
  parameter int HOT_LVL      = 196,
  parameter int HYST         = 28,
  parameter int KICK_PERIODS = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] ctl1_lvl,
  input  logic [LVL_W-1:0] ctl2_lvl,
  input  logic [LVL_W-1:0] slp_lvl,
  input  logic             period_start,
  output logic             pwm_en,
  output logic             force_high,
  output logic             hot_n,
  output logic             out_float
);
  import fan_seq_pkg::*;

  logic stop_now, start_ok, hot, sleep_req, wake_req;
  logic stop_s, kick_done;
  fan_mode_e mode_q, mode_d;

  fan_lvl_cmp #(
    .LVL_W(LVL_W), .STOP_LO(STOP_LO), .START_HI(START_HI),
    .HOT_LVL(HOT_LVL), .HYST(HYST)
  ) u_cmp (
    .ctl1_lvl (ctl1_lvl),
    .ctl2_lvl (ctl2_lvl),
    .slp_lvl  (slp_lvl),
    .stop_now (stop_now),
    .start_ok (start_ok),
    .hot      (hot),
    .sleep_req(sleep_req),
    .wake_req (wake_req)
  );

  fan_stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (stop_now),
    .q    (stop_s)
  );

  fan_kick_cnt #(.KICK_PERIODS(KICK_PERIODS)) u_kick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (mode_q != MODE_KICK),
    .tick (period_start),
    .done (kick_done)
  );

  always_comb begin
    mode_d = mode_q;
    if (stop_s) begin
      mode_d = MODE_OFF;
    end else begin
      unique case (mode_q)
        MODE_OFF:   if (start_ok)  mode_d = MODE_KICK;
        MODE_KICK:  if (kick_done) mode_d = MODE_RUN;
        MODE_RUN:   if (sleep_req) mode_d = MODE_SLEEP;
        MODE_SLEEP: if (wake_req)  mode_d = MODE_KICK;
        default:    mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_d;

  // Output gating uses the raw stop compare so the drive drops without a clock.
  always_comb begin
    pwm_en     = (mode_q == MODE_RUN)   && !stop_now;
    force_high = (mode_q == MODE_KICK)  && !stop_now;
    out_float  = (mode_q == MODE_SLEEP) && !stop_now;
    hot_n      = !(hot && !stop_now &&
                   ((mode_q == MODE_KICK) || (mode_q == MODE_RUN)));
  end
endmodule

// File: rtl/fan_mode_seq_chk.sv
module fan_mode_seq_chk #(
  parameter int LVL_W   = 8,
  parameter int STOP_LO = 12,
  parameter int HOT_LVL = 196
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] ctl1_lvl,
  input logic [LVL_W-1:0] slp_lvl,
  input logic [1:0]       mode_q,
  input logic             pwm_en,
  input logic             force_high,
  input logic             hot_n,
  input logic             out_float
);
  a_r2_stop_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1_lvl < LVL_W'(STOP_LO)) |-> (!pwm_en && !force_high && !out_float && hot_n));

  a_r8_hot_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    !hot_n |-> (ctl1_lvl > LVL_W'(HOT_LVL)));

  a_r9_sleep_no_hot: assert property (@(posedge clk) disable iff (!rst_n)
    out_float |-> (hot_n && !pwm_en));

  a_r10_one_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwm_en, force_high, out_float}));

  // R4: the running mode is only reached from the kick
  a_r4_run_after_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && $past(mode_q) != 2'd2) |-> ($past(mode_q) == 2'd1));

  a_r7_zero_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && slp_lvl == '0) |=> (mode_q != 2'd3));
endmodule

bind fan_mode_seq fan_mode_seq_chk #(
  .LVL_W(LVL_W), .STOP_LO(STOP_LO), .HOT_LVL(HOT_LVL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl1_lvl  (ctl1_lvl),
  .slp_lvl   (slp_lvl),
  .mode_q    (mode_q),
  .pwm_en    (pwm_en),
  .force_high(force_high),
  .hot_n     (hot_n),
  .out_float (out_float)
);

// File: tb/fan_mode_seq_tb.sv
module fan_mode_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctl1_lvl = 8'd100;
  logic [7:0] ctl2_lvl = 8'd100;
  logic [7:0] slp_lvl = 8'd0;
  logic       period_start = 1'b0;
  logic       pwm_en, force_high, hot_n, out_float;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fan_mode_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctl1_lvl(ctl1_lvl), .ctl2_lvl(ctl2_lvl),
    .slp_lvl(slp_lvl), .period_start(period_start), .pwm_en(pwm_en),
    .force_high(force_high), .hot_n(hot_n), .out_float(out_float)
  );

  function automatic logic [3:0] pack_out(logic p, logic f, logic h, logic fl);
    return {p, f, h, fl};
  endfunction

  function automatic logic exp_hot_n(logic [7:0] l1);
    return !(l1 > 8'd196);
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pwm,force,hot_n,float} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic outs(string req, logic p, logic f, logic h, logic fl);
    chk(req, pack_out(pwm_en, force_high, hot_n, out_float), pack_out(p, f, h, fl));
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      period_start = 1'b1;
      step(1);
      period_start = 1'b0;
      step(2);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd1234));
    step(3);
    outs("R1 in reset", 0, 0, 1, 0);
    rst_n = 1'b1;
    step(3);
    outs("R1 kick after power-up", 0, 1, 1, 0);

    pulses(63);
    outs("R4 still kicking after 63", 0, 1, 1, 0);
    pulses(1);
    outs("R4 running after 64", 1, 0, 1, 0);

    // R7: sleep disabled with slp_lvl zero, also random R8/R10 checks
    ctl1_lvl = 8'd25; ctl2_lvl = 8'd25;
    step(5);
    outs("R7 zero sleep level keeps running", 1, 0, 1, 0);
    for (int i = 0; i < 40; i++) begin
      a = 8'(30 + ($urandom % 226));
      b = 8'(30 + ($urandom % 226));
      ctl1_lvl = a; ctl2_lvl = b;
      step(2);
      outs("R8 hot flag while running", 1, 0, exp_hot_n(a), 0);
    end

    // R5: sleep entry
    slp_lvl = 8'd60; ctl1_lvl = 8'd50; ctl2_lvl = 8'd70;
    step(3);
    outs("R5 one level low stays running", 1, 0, 1, 0);
    ctl2_lvl = 8'd50;
    step(3);
    outs("R5 both low sleeps", 0, 0, 1, 1);
    // R6: wake needs slp+28 = 88
    ctl2_lvl = 8'd88;
    step(3);
    outs("R6 at wake level stays asleep", 0, 0, 1, 1);
    ctl2_lvl = 8'd89;
    step(3);
    outs("R6 wake starts kick", 0, 1, 1, 0);
    pulses(64);
    outs("R6 running after wake kick", 1, 0, 1, 0);

    // R9: hot level asleep
    slp_lvl = 8'd250; ctl1_lvl = 8'd230; ctl2_lvl = 8'd100;
    step(3);
    outs("R9 sleep hides hot flag", 0, 0, 1, 1);
    slp_lvl = 8'd60;
    step(3);
    outs("R8 hot flag during kick", 0, 1, 0, 0);
    pulses(64);
    outs("R8 hot while running full", 1, 0, 0, 0);

    // R2: immediate stop
    ctl2_lvl = 8'd255; ctl1_lvl = 8'd5;
    #1;
    outs("R2 stop same cycle", 0, 0, 1, 0);
    step(5);
    outs("R2 stays stopped", 0, 0, 1, 0);
    ctl1_lvl = 8'd15;
    step(6);
    outs("R3 band keeps stopped", 0, 0, 1, 0);
    ctl1_lvl = 8'd20;
    step(6);
    outs("R3 at start threshold still stopped", 0, 0, 1, 0);
    ctl1_lvl = 8'd100;
    step(5);
    outs("R3 release starts kick", 0, 1, 1, 0);
    pulses(64);
    outs("R3 running after release", 1, 0, 1, 0);

    done = 1'b1;
    finish_run();
  end
endmodule